// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits next to a small 8-bit processor core and gathers five interrupt request lines into a single delivery per instruction boundary. One line is non-maskable. Three are restart-style lines with fixed vector addresses. One is a general request whose handler instruction comes from the peripheral. Each line has its own trigger rule:

- The non-maskable line needs a rising edge and must then stay high.
- One restart line is latched on a rising edge.
- The other two restart lines and the general request follow the level.

The three restart lines pass through individual masks. Every maskable line also passes through a global enable. A fixed priority then chooses the winner.

When the core raises its instruction-boundary strobe and nothing is outstanding, the controller registers the winning request. A vectored source shows up as a valid flag plus a 16-bit vector. The general request shows up as an active-low acknowledge instead. The output stays unchanged until the core accepts it. Enable and disable commands and a mask-write port shape the gating. A status word reports the masks, the enable and the pending state of the three restart lines.

The reset input is asserted asynchronously and released through a small synchronizer. The core logic therefore leaves reset a fixed number of clock cycles after `rst_n` rises.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Requests are ranked by line index in `req_lines`, highest index first: bit 4 (non-maskable), then bit 3 (edge restart), bit 2 (upper level restart), bit 1 (lower level restart), bit 0 (general request). Only the highest eligible request is delivered.
- R2: Delivered vectors are fixed:
  - bit 4: 0x0024
  - bit 3: 0x003C
  - bit 2: 0x0034
  - bit 1: 0x002C
- R3: The non-maskable line ignores the masks and the global enable. It becomes pending only on a rising edge. It is dropped if the line falls before delivery. It is cleared when its delivery is accepted, and a line held high does not re-trigger.
- R4: The edge restart line (bit 3) latches a rising edge, and the latch stays set after the line falls and while it is masked. It is cleared by a disable command, by a mask write with `mask_clr_edge` set, or when its own delivery is accepted.
- R5: Bits 2 and 1 are level requests. Their pending state is the level sampled on the last clock edge, and they are eligible only when unmasked and globally enabled.
- R6: An eligible general request (bit 0) that wins produces `intr_ack_n` low with `irq_valid` low and `irq_vector` 0. `irq_valid` and `intr_ack_n` low never occur together.
- R7: A request is loaded into the output registers only on a clock edge where `insn_done` is high and no output is outstanding. It is visible after that edge.
- R8: An outstanding output keeps `irq_valid`, `irq_vector` and `intr_ack_n` unchanged until `core_accept` is high on a clock edge. After that edge it returns to idle (valid 0, vector 0, acknowledge high).
- R9: The global enable is handled as follows:
  - `en_cmd` sets it.
  - `dis_cmd` clears it, and wins if both commands arrive together.
  - Accepting any delivery other than the non-maskable one clears it.
  - Accepting a non-maskable delivery leaves it unchanged.
- R10: A clock edge with `mask_wr` high loads `mask_bits` into the masks: bit 2 masks line 3, bit 1 masks line 2, bit 0 masks line 1, and 1 means masked.
- R11: `status` layout:
  - bits [2:0]: the masks, in the `mask_bits` order
  - bit 3: the global enable
  - bit 6: line 3 pending
  - bit 5: line 2 pending
  - bit 4: line 1 pending
- R12: After reset the state is:
  - all masks set and the enable clear, so `status` = 0x07
  - no pending state
  - `irq_valid` 0, `irq_vector` 0, `intr_ack_n` 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_lines | input | 5 | Interrupt request lines; bit 4 non-maskable, bit 0 general request |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| core_accept | input | 1 | Core takes the outstanding delivery |
| en_cmd | input | 1 | Set the global enable |
| dis_cmd | input | 1 | Clear the global enable and the edge latch |
| mask_wr | input | 1 | Mask-write strobe |
| mask_bits | input | 3 | New mask values for lines 3, 2, 1 (bits 2, 1, 0) |
| mask_clr_edge | input | 1 | With `mask_wr`, clears the edge latch of line 3 |
| irq_valid | output | 1 | A vectored delivery is outstanding |
| irq_vector | output | 16 | Vector address of the outstanding delivery |
| intr_ack_n | output | 1 | Active-low acknowledge for the general request |
| status | output | 7 | Masks, global enable and restart-line pending bits |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between rising edges. They also assume that `core_accept` means something only while a delivery is outstanding, and that the commands are one-cycle pulses. The bench drives every input just after a falling edge and samples just after the next falling edge. It raises `core_accept` only after it has seen an output appear, and returns every command strobe to zero after one cycle. The non-maskable line is held high through acceptance whenever a check expects its delivery.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned SRC_W    = $clog2(NUM_SRC);
  localparam int unsigned VEC_W    = 16;
  localparam int unsigned NUM_MASK = 3;
  localparam int unsigned STAT_W   = 2 * NUM_MASK + 1;

  // line indices; a higher index wins
  localparam int unsigned SRC_NMI = 4;
  localparam int unsigned SRC_EDG = 3;
  localparam int unsigned SRC_LHI = 2;
  localparam int unsigned SRC_LLO = 1;
  localparam int unsigned SRC_GEN = 0;

  typedef enum logic [1:0] {
    TRIG_EDGE_HELD,
    TRIG_EDGE_LATCH,
    TRIG_LEVEL
  } trig_e;

  function automatic trig_e trig_of(input int unsigned idx);
    case (idx)
      SRC_NMI: trig_of = TRIG_EDGE_HELD;
      SRC_EDG: trig_of = TRIG_EDGE_LATCH;
      default: trig_of = TRIG_LEVEL;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
    case (idx)
      SRC_NMI: vec_of = VEC_W'(16'h0024);
      SRC_EDG: vec_of = VEC_W'(16'h003C);
      SRC_LHI: vec_of = VEC_W'(16'h0034);
      SRC_LLO: vec_of = VEC_W'(16'h002C);
      default: vec_of = '0;
    endcase
  endfunction

endpackage

// File: rtl/irq_line_trig.sv
module irq_line_trig
  import irq_vec_pkg::*;
#(
  parameter trig_e MODE = TRIG_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic clr,
  output logic pend
);

  logic prev_q;
  logic pend_q;
  logic pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line;
      pend_q <= pend_d;
    end
  end

  generate
    if (MODE == TRIG_EDGE_HELD) begin : g_edge_held
      always_comb begin
        pend_d = pend_q;
        if (!line || clr) begin
          pend_d = 1'b0;
        end else if (!prev_q) begin
          pend_d = 1'b1;
        end
      end

      AST_NMI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !line |=> !pend_q); // R3
      AST_NMI_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && prev_q) |=> !pend_q); // R3
    end else if (MODE == TRIG_EDGE_LATCH) begin : g_edge_latch
      always_comb begin
        pend_d = pend_q;
        if (clr) begin
          pend_d = 1'b0;
        end
        if (line && !prev_q) begin
          pend_d = 1'b1;
        end
      end

      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr) |=> pend_q); // R4
      AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (line && !prev_q) |=> pend_q); // R4
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = clr ^ prev_q;
      always_comb pend_d = line;

      AST_LVL_FOLLOW_HI: assert property (@(posedge clk) disable iff (!rst_n)
        line |=> pend_q); // R5
      AST_LVL_FOLLOW_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !line |=> !pend_q); // R5
    end
  endgenerate

  assign pend = pend_q;

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_vec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_cmd,
  input  logic                dis_cmd,
  input  logic                mask_wr,
  input  logic [NUM_MASK-1:0] mask_bits,
  input  logic                take_maskable,
  output logic [NUM_MASK-1:0] mask,
  output logic                ie
);

  logic [NUM_MASK-1:0] mask_q;
  logic [NUM_MASK-1:0] mask_d;
  logic                ie_q;
  logic                ie_d;

  always_comb begin
    mask_d = mask_q;
    if (mask_wr) begin
      mask_d = mask_bits;
    end
    ie_d = ie_q;
    if (dis_cmd || take_maskable) begin
      ie_d = 1'b0;
    end else if (en_cmd) begin
      ie_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ie_q   <= ie_d;
    end
  end

  assign mask = mask_q;
  assign ie   = ie_q;

  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> !ie_q); // R9
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd && !dis_cmd && !take_maskable) |=> ie_q); // R9
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_bits))); // R10
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)); // R10

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_vec_pkg::*;
#(
  parameter int unsigned N     = NUM_SRC,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        pend,
  input  logic [NUM_MASK-1:0] mask,
  input  logic                ie,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);

  logic [N-1:0] elig;
  logic [N-1:0] above;
  logic [N-1:0] grant;

  for (genvar i = 0; i < N; i++) begin : g_elig
    if (i == N - 1) begin : g_top
      assign elig[i]  = pend[i];
      assign above[i] = 1'b0;
    end else begin : g_rest
      if (i == 0) begin : g_gen
        assign elig[i] = pend[i] & ie;
      end else begin : g_msk
        assign elig[i] = pend[i] & ~mask[i-1] & ie;
      end
      assign above[i] = above[i+1] | elig[i+1];
    end
    assign grant[i] = elig[i] & ~above[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        idx = IDX_W'(i);
      end
    end
  end

  assign any = |elig;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1
  AST_NMI_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    pend[N-1] |-> (any && idx == IDX_W'(N - 1))); // R3

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  req_lines,
  input  logic                insn_done,
  input  logic                core_accept,
  input  logic                en_cmd,
  input  logic                dis_cmd,
  input  logic                mask_wr,
  input  logic [NUM_MASK-1:0] mask_bits,
  input  logic                mask_clr_edge,
  output logic                irq_valid,
  output logic [VEC_W-1:0]    irq_vector,
  output logic                intr_ack_n,
  output logic [STAT_W-1:0]   status
);

  // reset: asserted at once, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[SYNC_STAGES-1];

  logic                valid_q, valid_d;
  logic                ackn_q, ackn_d;
  logic [VEC_W-1:0]    vec_q, vec_d;
  logic [SRC_W-1:0]    src_q, src_d;
  logic                busy;
  logic                take;
  logic [NUM_SRC-1:0]  ack_src;
  logic [NUM_SRC-1:0]  pend;
  logic [NUM_MASK-1:0] mask;
  logic                ie;
  logic                win_any;
  logic [SRC_W-1:0]    win_idx;

  assign busy = valid_q | ~ackn_q;
  assign take = core_accept & busy;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    logic clr_g;
    assign ack_src[g] = take && (src_q == SRC_W'(g));
    if (g == SRC_EDG) begin : g_edg_clr
      assign clr_g = ack_src[g] | dis_cmd | (mask_wr & mask_clr_edge);
    end else begin : g_ack_clr
      assign clr_g = ack_src[g];
    end
    irq_line_trig #(
      .MODE(trig_of(g))
    ) u_trig (
      .clk  (clk),
      .rst_n(rst_core_n),
      .line (req_lines[g]),
      .clr  (clr_g),
      .pend (pend[g])
    );
  end

  irq_ctrl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .en_cmd       (en_cmd),
    .dis_cmd      (dis_cmd),
    .mask_wr      (mask_wr),
    .mask_bits    (mask_bits),
    .take_maskable(take && (src_q != SRC_W'(SRC_NMI))),
    .mask         (mask),
    .ie           (ie)
  );

  irq_prio_pick #(
    .N    (NUM_SRC),
    .IDX_W(SRC_W)
  ) u_pick (
    .clk  (clk),
    .rst_n(rst_core_n),
    .pend (pend),
    .mask (mask),
    .ie   (ie),
    .any  (win_any),
    .idx  (win_idx)
  );

  always_comb begin
    valid_d = valid_q;
    ackn_d  = ackn_q;
    vec_d   = vec_q;
    src_d   = src_q;
    if (take) begin
      valid_d = 1'b0;
      ackn_d  = 1'b1;
      vec_d   = '0;
    end else if (!busy && insn_done && win_any) begin
      src_d = win_idx;
      vec_d = vec_of(int'(win_idx));
      if (win_idx == SRC_W'(SRC_GEN)) begin
        ackn_d = 1'b0;
      end else begin
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      ackn_q  <= 1'b1;
      vec_q   <= '0;
      src_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ackn_q  <= ackn_d;
      vec_q   <= vec_d;
      src_q   <= src_d;
    end
  end

  assign irq_valid  = valid_q;
  assign intr_ack_n = ackn_q;
  assign irq_vector = vec_q;
  assign status     = {pend[SRC_EDG], pend[SRC_LHI], pend[SRC_LLO], ie, mask};

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(valid_q && !ackn_q)); // R6
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && !core_accept) |=> ($stable(valid_q) && $stable(ackn_q) && $stable(vec_q))); // R8
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_core_n)
    take |=> (!valid_q && ackn_q && vec_q == '0)); // R8
  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!busy && !insn_done) |=> (!valid_q && ackn_q)); // R7
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_core_n)
    valid_q |-> (vec_q inside {16'h0024, 16'h003C, 16'h0034, 16'h002C})); // R2
  AST_IE_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_core_n)
    (take && src_q != SRC_W'(SRC_NMI)) |=> !ie); // R9

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req_lines = '0;
  logic        insn_done = 1'b0;
  logic        core_accept = 1'b0;
  logic        en_cmd = 1'b0;
  logic        dis_cmd = 1'b0;
  logic        mask_wr = 1'b0;
  logic [2:0]  mask_bits = '0;
  logic        mask_clr_edge = 1'b0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic        intr_ack_n;
  logic [6:0]  status;

  int total = 0;
  int passed = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_lines    (req_lines),
    .insn_done    (insn_done),
    .core_accept  (core_accept),
    .en_cmd       (en_cmd),
    .dis_cmd      (dis_cmd),
    .mask_wr      (mask_wr),
    .mask_bits    (mask_bits),
    .mask_clr_edge(mask_clr_edge),
    .irq_valid    (irq_valid),
    .irq_vector   (irq_vector),
    .intr_ack_n   (intr_ack_n),
    .status       (status)
  );

  // row: lines[26:22] mask[21:19] ie[18] exp_valid[17] exp_vec[16:1] exp_ackn[0]
  localparam logic [26:0] TBL [12] = '{
    {5'b11111, 3'b000, 1'b1, 1'b1, 16'h0024, 1'b1},
    {5'b01111, 3'b000, 1'b1, 1'b1, 16'h003C, 1'b1},
    {5'b00111, 3'b000, 1'b1, 1'b1, 16'h0034, 1'b1},
    {5'b00011, 3'b000, 1'b1, 1'b1, 16'h002C, 1'b1},
    {5'b00001, 3'b000, 1'b1, 1'b0, 16'h0000, 1'b0},
    {5'b01111, 3'b100, 1'b1, 1'b1, 16'h0034, 1'b1},
    {5'b00111, 3'b010, 1'b1, 1'b1, 16'h002C, 1'b1},
    {5'b00011, 3'b001, 1'b1, 1'b0, 16'h0000, 1'b0},
    {5'b00010, 3'b111, 1'b1, 1'b0, 16'h0000, 1'b1},
    {5'b10000, 3'b111, 1'b1, 1'b1, 16'h0024, 1'b1},
    {5'b01111, 3'b000, 1'b0, 1'b0, 16'h0000, 1'b1},
    {5'b11111, 3'b000, 1'b0, 1'b1, 16'h0024, 1'b1}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_lines = '0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  task automatic write_mask(input logic [2:0] m, input logic clr);
    mask_wr = 1'b1; mask_bits = m; mask_clr_edge = clr;
    step();
    mask_wr = 1'b0; mask_clr_edge = 1'b0;
  endtask

  task automatic enable();
    en_cmd = 1'b1; step(); en_cmd = 1'b0;
  endtask

  task automatic boundary();
    insn_done = 1'b1; step(); insn_done = 1'b0;
  endtask

  task automatic accept();
    core_accept = 1'b1; step(); core_accept = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    do_reset();
    // R12: reset state
    chk("R12 status", 32'(status), 32'h07);
    chk("R12 valid", 32'(irq_valid), 32'h0);
    chk("R12 ack_n", 32'(intr_ack_n), 32'h1);
    chk("R12 vector", 32'(irq_vector), 32'h0);

    // table walk: R1 priority, R2 vectors, R5/R6 gating
    for (int r = 0; r < 12; r++) begin
      logic [26:0] row;
      row = TBL[r];
      do_reset();
      write_mask(row[21:19], 1'b0);
      if (row[18]) enable();
      req_lines = row[26:22];
      step();
      boundary();
      chk($sformatf("R1 row%0d valid", r), 32'(irq_valid), 32'(row[17]));
      chk($sformatf("R2 row%0d vector", r), 32'(irq_vector), 32'(row[16:1]));
      chk($sformatf("R6 row%0d ack_n", r), 32'(intr_ack_n), 32'(row[0]));
      accept();
      chk($sformatf("R8 row%0d idle", r), {30'b0, irq_valid, intr_ack_n}, 32'h1);
      req_lines = '0;
      step();
    end

    // R7: no delivery without boundary; R8: hold until accept
    do_reset();
    write_mask(3'b000, 1'b0);
    enable();
    req_lines = 5'b00100;
    step(); step();
    chk("R7 no boundary", 32'(irq_valid), 32'h0);
    boundary();
    chk("R7 at boundary", 32'(irq_vector), 32'h0034);
    req_lines = 5'b10100;
    step(); step(); step();
    chk("R8 held vector", 32'(irq_vector), 32'h0034);
    chk("R8 held valid", 32'(irq_valid), 32'h1);
    accept();
    chk("R8 released", 32'(irq_valid), 32'h0);
    chk("R9 ie auto clear", 32'(status[3]), 32'h0);
    boundary();
    chk("R3 nmi with ie off", 32'(irq_vector), 32'h0024);
    accept();
    boundary();
    chk("R3 no retrigger", 32'(irq_valid), 32'h0);
    req_lines = '0;
    step();

    // R4: edge latch behaviour
    enable();
    write_mask(3'b100, 1'b0);
    req_lines = 5'b01000; step();
    req_lines = '0; step();
    chk("R4 latch sticky", 32'(status[6]), 32'h1);
    boundary();
    chk("R4 masked no delivery", 32'(irq_valid), 32'h0);
    write_mask(3'b000, 1'b0);
    boundary();
    chk("R4 unmasked delivery", 32'(irq_vector), 32'h003C);
    accept();
    chk("R4 cleared on accept", 32'(status[6]), 32'h0);
    enable();
    req_lines = 5'b01000; step();
    req_lines = '0;
    write_mask(3'b111, 1'b1);
    chk("R4 mask write clears latch", 32'(status[6]), 32'h0);
    chk("R10 mask value", 32'(status[2:0]), 32'h7);
    req_lines = 5'b01000; step();
    req_lines = '0;
    dis_cmd = 1'b1; step(); dis_cmd = 1'b0;
    chk("R4 disable clears latch", 32'(status[6]), 32'h0);
    chk("R9 disable clears ie", 32'(status[3]), 32'h0);

    // R3: line dropped before delivery
    enable();
    req_lines = 5'b10000; step();
    req_lines = '0; step();
    boundary();
    chk("R3 dropped line", 32'(irq_valid), 32'h0);

    // R9: nmi accept keeps ie; both commands -> disabled
    req_lines = 5'b10000; step();
    boundary();
    accept();
    chk("R9 nmi keeps ie", 32'(status[3]), 32'h1);
    req_lines = '0;
    en_cmd = 1'b1; dis_cmd = 1'b1; step();
    en_cmd = 1'b0; dis_cmd = 1'b0;
    chk("R9 disable wins", 32'(status[3]), 32'h0);

    // R10/R11/R5: mask layout and level pending
    write_mask(3'b101, 1'b0);
    chk("R10 mask bits", 32'(status[2:0]), 32'h5);
    req_lines = 5'b00100; step();
    chk("R11 level pending bit", 32'(status[6:4]), 32'h2);
    req_lines = 5'b00010; step();
    chk("R11 lower pending bit", 32'(status[6:4]), 32'h1);
    req_lines = '0; step();
    chk("R5 level dropped", 32'(status[6:4]), 32'h0);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule